// File: doc/BRIEF.md
# Video Lock Status Hysteresis Filter

This block turns raw, per-line horizontal lock indications from a video sync front end into a debounced overall lock status. One of two raw sources is used. The first is a slow source that judges several fields and takes vertical sync into account. The second is a fast source that judges the horizontal sync pulse line by line. The chosen source can also be qualified by a colour-subcarrier lock flag. The filter only does work on a line strobe, which pulses once per video line. Every count is therefore a count of video lines, not of clock cycles.

The filter enters the locked state only after the condition has held on a programmed number of consecutive lines. It leaves that state only after the condition has failed on a second, separately programmed number of consecutive lines. Each threshold is set by a 3-bit code on a nonlinear scale that runs from 1 line up to 100,000 lines. The result appears on a 2-bit status field and a horizontal-lock flag.

Top module: `vlock_filter`

## Requirements
- R1: While reset is asserted and at the first cycle after it, status[0] and hlock read 0 (unlocked), and the internal line count is empty.
- R2: When cfg_src_fast is 0, the raw condition comes from raw_slow. When it is 1, the raw condition comes from raw_fast.
- R3: When cfg_sc_en is 0, the lock condition is the selected raw source alone. When it is 1, the condition is the selected source ANDed with sc_lock.
- R4: cfg_enter codes 0,1,2,3,4,5,6,7 require 1, 2, 5, 10, 100, 500, 1000 and 100,000 consecutive strobed lines with the condition true before status[0] becomes 1. status[0] changes on the clock edge that samples the last required strobe.
- R5: cfg_leave uses the same code-to-line mapping as R4. It sets how many consecutive strobed lines with the condition false are needed before status[0] returns to 0.
- R6: A strobed line on which the condition agrees with the current debounced state clears the run. Counting then starts again from zero.
- R7: Clock cycles without line_stb neither advance the count nor change status[0]. Raw inputs are sampled only on strobed cycles.
- R8: status[1] shows the current combinational lock condition (the source chosen by R2, gated as in R3). status[0] is the debounced state, and hlock always equals status[0].
- R9: A change to cfg_enter or cfg_leave applies at the next strobe. That strobe's updated run length is compared with the new threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | One-cycle pulse per video line |
| raw_slow | input | 1 | Multi-field raw lock with vertical awareness |
| raw_fast | input | 1 | Line-by-line raw horizontal sync lock |
| sc_lock | input | 1 | Colour-subcarrier loop lock flag |
| cfg_src_fast | input | 1 | Raw source select (0 slow, 1 fast) |
| cfg_sc_en | input | 1 | Require subcarrier lock in the condition |
| cfg_enter | input | 3 | Count-into-lock threshold code |
| cfg_leave | input | 3 | Count-out-of-lock threshold code |
| status | output | 2 | [0] debounced lock, [1] current raw condition |
| hlock | output | 1 | Debounced horizontal lock flag |

## Verification
The assertions assume that every input is synchronous to clk and holds a known value from the first clock edge after reset. They also assume the raw flags matter only on cycles where line_stb is high. The bench changes inputs a fixed time after each rising edge, so nothing changes at the sampling edge. It drives all inputs to defined levels before it releases reset. The bench sends strobes both back to back and spaced apart. It varies the threshold codes only between edges, which keeps the assumption behind the R9 timing intact.

// File: rtl/vlock_pkg.sv
package vlock_pkg;
  localparam int LINE_CNT_W = 17;
  localparam int CODE_W     = 3;

  // Nonlinear code-to-line threshold scale used for both directions
  function automatic logic [LINE_CNT_W-1:0] lines_for_code(input logic [CODE_W-1:0] code);
    logic [LINE_CNT_W-1:0] n;
    case (code)
      3'd0:    n = LINE_CNT_W'(1);
      3'd1:    n = LINE_CNT_W'(2);
      3'd2:    n = LINE_CNT_W'(5);
      3'd3:    n = LINE_CNT_W'(10);
      3'd4:    n = LINE_CNT_W'(100);
      3'd5:    n = LINE_CNT_W'(500);
      3'd6:    n = LINE_CNT_W'(1000);
      default: n = LINE_CNT_W'(100000);
    endcase
    return n;
  endfunction
endpackage

// File: rtl/vlock_cond_sel.sv
module vlock_cond_sel (
  input  logic raw_slow,
  input  logic raw_fast,
  input  logic sc_lock,
  input  logic src_fast,
  input  logic sc_en,
  output logic cond
);
  logic raw_pick;
  assign raw_pick = src_fast ? raw_fast : raw_slow;
  assign cond     = raw_pick & (sc_lock | ~sc_en);
endmodule

// File: rtl/vlock_hyst.sv
module vlock_hyst #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb,
  input  logic             cond,
  input  logic [CNT_W-1:0] thr_enter,
  input  logic [CNT_W-1:0] thr_leave,
  output logic             locked
);
  logic             locked_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr_sel;
  logic [CNT_W-1:0] cnt_inc;
  logic             differ;
  logic             reach;
  logic             flip_ev;
  logic             run_clr;

  assign differ  = cond != locked_q;
  assign thr_sel = locked_q ? thr_leave : thr_enter;
  assign cnt_inc = cnt_q + 1'b1;
  assign reach   = differ && (cnt_inc >= thr_sel);
  assign flip_ev = stb && reach;
  assign run_clr = stb && !differ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      cnt_q    <= '0;
    end else if (stb) begin
      if (!differ) begin
        cnt_q <= '0;
      end else if (reach) begin
        locked_q <= ~locked_q;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_inc;
      end
    end
  end

  assign locked = locked_q;

  // R7
  hold_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !stb |=> ($stable(locked_q) && $stable(cnt_q)));

  // R6
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_clr |=> (cnt_q == '0));

  // R4
  enter_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> $past(stb && cond));

  // R5
  leave_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked_q) |-> $past(stb && !cond));

  // R4
  flip_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flip_ev |=> (cnt_q == '0));
endmodule

// File: rtl/vlock_filter.sv
module vlock_filter #(
  parameter int CNT_W  = vlock_pkg::LINE_CNT_W,
  parameter int CODE_W = vlock_pkg::CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_stb,
  input  logic              raw_slow,
  input  logic              raw_fast,
  input  logic              sc_lock,
  input  logic              cfg_src_fast,
  input  logic              cfg_sc_en,
  input  logic [CODE_W-1:0] cfg_enter,
  input  logic [CODE_W-1:0] cfg_leave,
  output logic [1:0]        status,
  output logic              hlock
);
  logic             cond_w;
  logic             locked_w;
  logic [CNT_W-1:0] thr_enter_w;
  logic [CNT_W-1:0] thr_leave_w;

  assign thr_enter_w = CNT_W'(vlock_pkg::lines_for_code(cfg_enter));
  assign thr_leave_w = CNT_W'(vlock_pkg::lines_for_code(cfg_leave));

  vlock_cond_sel u_sel (
    .raw_slow (raw_slow),
    .raw_fast (raw_fast),
    .sc_lock  (sc_lock),
    .src_fast (cfg_src_fast),
    .sc_en    (cfg_sc_en),
    .cond     (cond_w)
  );

  vlock_hyst #(.CNT_W(CNT_W)) u_hyst (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (line_stb),
    .cond      (cond_w),
    .thr_enter (thr_enter_w),
    .thr_leave (thr_leave_w),
    .locked    (locked_w)
  );

  assign status = {cond_w, locked_w};
  assign hlock  = locked_w;

  // R3
  sc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_sc_en && !sc_lock) |-> !status[1]);

  // R8
  hlock_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hlock == status[0]);

  // R1
  reset_unlocked_chk: assert property (@(posedge clk)
    !rst_n |=> !hlock);
endmodule

// File: tb/vlock_filter_bench.sv
module vlock_filter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_stb = 1'b0, raw_slow = 1'b0, raw_fast = 1'b0, sc_lock = 1'b0;
  logic       cfg_src_fast = 1'b0, cfg_sc_en = 1'b0;
  logic [2:0] cfg_enter = 3'd4, cfg_leave = 3'd4;
  logic [1:0] status;
  logic       hlock;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";

  int tab [8] = '{1, 2, 5, 10, 100, 500, 1000, 100000};
  int m_run = 0;
  bit m_lock = 1'b0;

  always #4 clk = ~clk;

  vlock_filter u_vlock_filter (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .raw_slow(raw_slow),
    .raw_fast(raw_fast), .sc_lock(sc_lock), .cfg_src_fast(cfg_src_fast),
    .cfg_sc_en(cfg_sc_en), .cfg_enter(cfg_enter), .cfg_leave(cfg_leave),
    .status(status), .hlock(hlock)
  );

  function automatic bit ref_cond();
    bit r;
    if (cfg_src_fast) r = raw_fast; else r = raw_slow;
    if (cfg_sc_en && !sc_lock) r = 1'b0;
    return r;
  endfunction

  // Behavioural reference: one update per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_lock = 1'b0;
    end else if (line_stb) begin
      if (ref_cond() == m_lock) m_run = 0;
      else begin
        m_run = m_run + 1;
        if (m_run >= (m_lock ? tab[cfg_leave] : tab[cfg_enter])) begin
          m_lock = !m_lock; m_run = 0;
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk);
    #2;
    vectors++;
    if (status[0] !== m_lock || hlock !== m_lock) begin
      fails++;
      $display("FAIL %s: status0=%b hlock=%b expected %b", cur_req, status[0], hlock, m_lock);
    end
    if (rst_n && status[1] !== ref_cond()) begin
      fails++;
      $display("FAIL %s: status1=%b expected %b", cur_req, status[1], ref_cond());
    end
  endtask

  // n strobed lines, gap idle cycles after each one
  task automatic lines(int n, int gap);
    for (int i = 0; i < n; i++) begin
      line_stb = 1'b1; cyc();
      line_stb = 1'b0;
      for (int g = 0; g < gap; g++) cyc();
    end
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    cur_req = "R1";
    for (int i = 0; i < 3; i++) cyc();
    rst_n = 1'b1;
    cyc();

    // R4/R5: 1-line enter, 2-line leave, back-to-back strobes
    cur_req = "R4"; cfg_src_fast = 1'b1; cfg_enter = 3'd0; cfg_leave = 3'd1;
    raw_fast = 1'b1; lines(1, 0); cyc();
    cur_req = "R5"; raw_fast = 1'b0; lines(1, 0); lines(1, 0); cyc();

    // R7: sparse strobes, raw toggles between strobes are ignored
    cur_req = "R7"; cfg_enter = 3'd1;
    raw_fast = 1'b1; line_stb = 1'b1; cyc(); line_stb = 1'b0;
    raw_fast = 1'b0; cyc(); cyc(); raw_fast = 1'b1; cyc();
    line_stb = 1'b1; cyc(); line_stb = 1'b0; cyc(); cyc();

    // R6: 5-line run broken one line short, then completed
    cur_req = "R6"; cfg_leave = 3'd2;
    raw_fast = 1'b0; lines(4, 1); raw_fast = 1'b1; lines(1, 1);
    raw_fast = 1'b0; lines(4, 2); lines(1, 1);

    // R2: source select
    cur_req = "R2"; cfg_enter = 3'd0; cfg_leave = 3'd0;
    raw_slow = 1'b1; raw_fast = 1'b0; cfg_src_fast = 1'b1; lines(2, 1);
    cfg_src_fast = 1'b0; lines(1, 1); raw_slow = 1'b0; raw_fast = 1'b1; lines(1, 1);

    // R3: subcarrier qualification
    cur_req = "R3"; cfg_src_fast = 1'b1; cfg_sc_en = 1'b1; sc_lock = 1'b0; lines(2, 1);
    sc_lock = 1'b1; lines(1, 1); sc_lock = 1'b0; lines(1, 1);
    cfg_sc_en = 1'b0; lines(1, 1);

    // R8: raw condition visible while debounced state lags
    cur_req = "R8"; cfg_leave = 3'd3; raw_fast = 1'b0; lines(5, 1);
    raw_slow = 1'b1; cfg_src_fast = 1'b0; cyc(); lines(1, 0);

    // R9: threshold lowered mid-run
    cur_req = "R9"; cfg_src_fast = 1'b1; cfg_enter = 3'd3; raw_fast = 1'b1;
    raw_fast = 1'b0; lines(10, 0); raw_fast = 1'b1; lines(3, 0);
    cfg_enter = 3'd1; lines(1, 0); cyc();

    // R4: largest code, 100,000 back-to-back lines
    cur_req = "R4"; cfg_leave = 3'd0; raw_fast = 1'b0; lines(1, 0);
    cfg_enter = 3'd7; raw_fast = 1'b1; lines(100000, 0); cyc();
    cur_req = "R5"; raw_fast = 1'b0; lines(1, 0); cyc();

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule